// File: doc/BRIEF.md
# External Interrupt Sense Controller

This peripheral watches two external interrupt pins, labelled channel 0 and channel 1. Each pin is first passed through a synchroniser. Software then picks one of four trigger conditions for each channel: low level, any change, falling edge or rising edge. When an edge condition is seen, the channel latches a pending flag. The block asks the processor for service when three things are all true: a channel is pending, that channel is enabled, and the global interrupt enable input is high.

Software reaches the block through a small byte-wide register port with three locations: sense control, channel enables and pending flags. A pending flag is cleared in one of two ways. Software can write a one to the flag's bit, or the processor can acknowledge the channel. When both channels request at the same time, a one-hot selection output presents channel 0 first.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, all three registers read zero and no request, selection or any-request output is high.
- R2: The sense control register (address 0) reads back all 8 written bits. Bits 1:0 select channel 0's trigger and bits 3:2 select channel 1's trigger, with the codes 00 low level, 01 any change, 10 falling edge and 11 rising edge. Bits 7:4 have no effect on detection.
- R3: The enable register (address 1) stores the channel 1 enable in bit 7 and the channel 0 enable in bit 6. All its other bits read as zero.
- R4: The flag register (address 2) shows the channel 1 flag in bit 7 and the channel 0 flag in bit 6. All its other bits read as zero.
- R5: In falling-edge mode, a high-to-low pin transition sets the flag, and the flag first reads one in the third cycle after the pin changes. A low-to-high transition leaves the flag clear.
- R6: In rising-edge mode, a low-to-high transition sets the flag and a high-to-low transition does not.
- R7: In any-change mode, every transition in either direction sets the flag.
- R8: In low-level mode, the request is high while the synchronised pin is low, starting two cycles after the pin falls. No flag is latched, so the request drops once the pin is high again.
- R9: Writing a one to a flag bit clears that flag. Writing a zero leaves it unchanged.
- R10: A one-cycle pulse on a channel's acknowledge input clears that channel's flag only.
- R11: A trigger that occurs in the same cycle as a clear leaves the flag set.
- R12: A channel's request is high only when the channel is pending, its enable bit is set and the global enable input is high.
- R13: The selection output is one-hot. When both channels request, it selects channel 0 (value 01).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 2 | Asynchronous external interrupt pins, bit c is channel c |
| gie | input | 1 | Global interrupt enable |
| ack | input | 2 | Per-channel service acknowledge, clears the flag |
| reg_addr | input | 2 | Register address: 0 sense, 1 enable, 2 flags |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| irq_req | output | 2 | Per-channel request |
| irq_sel | output | 2 | One-hot selection of the highest-priority request |
| irq_any | output | 1 | Any request is high |

## Verification
The case that is hardest to reach from the ports is a trigger and a clear landing in the same clock cycle. The trigger only arrives after the synchroniser delay, so the bench changes a pin and then counts cycles. It raises the acknowledge exactly in the cycle when the edge event reaches the flag, and it does this on a flag that is already set, so that a clear winning over the set would be visible. Random register writes, acknowledges, global-enable changes and pin transitions are checked against a transaction-level model. Between pin changes the bench waits long enough for the synchroniser to settle.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
   localparam int NUM_CH = 2;
   localparam int AW     = 2;
   localparam int DW     = 8;

   typedef enum logic [1:0] {
      SENSE_LOW  = 2'b00,
      SENSE_ANY  = 2'b01,
      SENSE_FALL = 2'b10,
      SENSE_RISE = 2'b11
   } sense_e;

   localparam logic [AW-1:0] ADDR_CTL = 2'd0;
   localparam logic [AW-1:0] ADDR_ENA = 2'd1;
   localparam logic [AW-1:0] ADDR_FLG = 2'd2;

   // channel c lives at bit CH_BIT_BASE + c of the enable and flag registers
   localparam int CH_BIT_BASE = 6;

   function automatic int ch_bit(input int c);
      return CH_BIT_BASE + c;
   endfunction
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
   parameter int   STAGES = 2,
   parameter logic IDLE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("eirq_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= {STAGES{IDLE}};
      else        sh_q <= {sh_q[STAGES-2:0], d};
   end

   assign q = sh_q[STAGES-1];
endmodule

// File: rtl/eirq_sense.sv
module eirq_sense
   import ext_irq_pkg::*;
#(
   parameter logic IDLE = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   lvl_in,
   input  sense_e mode,
   output logic   evt,
   output logic   lvl_act
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE;
      else        prev_q <= lvl_in;
   end

   always_comb begin
      unique case (mode)
         SENSE_ANY:  evt = prev_q ^ lvl_in;
         SENSE_FALL: evt = prev_q & ~lvl_in;
         SENSE_RISE: evt = ~prev_q & lvl_in;
         default:    evt = 1'b0;
      endcase
   end

   assign lvl_act = (mode == SENSE_LOW) & ~lvl_in;

   // an event always coincides with a change of the synchronised pin
   assert_evt_is_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
      evt |-> (lvl_in != $past(lvl_in)));
   // level mode never produces an event
   assert_level_no_evt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == SENSE_LOW) |-> !evt);
endmodule

// File: rtl/eirq_flag.sv
module eirq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end

   assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> flag);
   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !flag);
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
   import ext_irq_pkg::*;
#(
   parameter int   SYNC_STAGES = 2,
   parameter logic PIN_IDLE    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] pin_in,
   input  logic              gie,
   input  logic [NUM_CH-1:0] ack,
   input  logic [AW-1:0]     reg_addr,
   input  logic              reg_wr,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   output logic [NUM_CH-1:0] irq_req,
   output logic [NUM_CH-1:0] irq_sel,
   output logic              irq_any
);
   localparam logic [NUM_CH-1:0] ONE = NUM_CH'(1);

   generate
      if (CH_BIT_BASE + NUM_CH > DW) begin : g_bad_map
         $error("channel bits do not fit the register width");
      end
      if (2 * NUM_CH > DW) begin : g_bad_ctl
         $error("sense fields do not fit the control register");
      end
   endgenerate

   logic [DW-1:0]     ctl_q;
   logic [NUM_CH-1:0] ena_q;
   logic [NUM_CH-1:0] flag;
   logic [NUM_CH-1:0] pend;
   logic [NUM_CH-1:0] sync_pin;
   logic [NUM_CH-1:0] evt;
   logic [NUM_CH-1:0] lvl_act;
   logic [NUM_CH-1:0] sw_clr;

   wire wr_ctl = reg_wr && (reg_addr == ADDR_CTL);
   wire wr_ena = reg_wr && (reg_addr == ADDR_ENA);
   wire wr_flg = reg_wr && (reg_addr == ADDR_FLG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         ena_q <= '0;
      end else begin
         if (wr_ctl) ctl_q <= reg_wdata;
         if (wr_ena) begin
            for (int c = 0; c < NUM_CH; c++) ena_q[c] <= reg_wdata[ch_bit(c)];
         end
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      eirq_sync #(.STAGES(SYNC_STAGES), .IDLE(PIN_IDLE)) u_sync (
         .clk(clk), .rst_n(rst_n), .d(pin_in[c]), .q(sync_pin[c]));

      eirq_sense #(.IDLE(PIN_IDLE)) u_sense (
         .clk(clk), .rst_n(rst_n), .lvl_in(sync_pin[c]),
         .mode(sense_e'(ctl_q[2*c +: 2])),
         .evt(evt[c]), .lvl_act(lvl_act[c]));

      assign sw_clr[c] = ack[c] | (wr_flg & reg_wdata[ch_bit(c)]);

      eirq_flag u_flag (
         .clk(clk), .rst_n(rst_n), .set(evt[c]), .clr(sw_clr[c]), .flag(flag[c]));
   end

   assign pend    = flag | lvl_act;
   assign irq_req = pend & ena_q & {NUM_CH{gie}};
   assign irq_sel = irq_req & (~irq_req + ONE);
   assign irq_any = |irq_req;

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         ADDR_CTL: reg_rdata = ctl_q;
         ADDR_ENA: for (int c = 0; c < NUM_CH; c++) reg_rdata[ch_bit(c)] = ena_q[c];
         ADDR_FLG: for (int c = 0; c < NUM_CH; c++) reg_rdata[ch_bit(c)] = flag[c];
         default:  reg_rdata = '0;
      endcase
   end

   assert_req_needs_gie_R12: assert property (@(posedge clk) disable iff (!rst_n)
      irq_any |-> gie);
   assert_req_needs_ena_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req & ~ena_q) == '0);
   assert_sel_onehot_R13: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_sel) && ((irq_sel == '0) == !irq_any));
   assert_sel_prio_R13: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[0] |-> irq_sel[0]);
   assert_flag_spare_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_FLG) |-> (reg_rdata[CH_BIT_BASE-1:0] == '0));
   assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[0] && !evt[0]) |=> !flag[0]);
endmodule

// File: tb/ext_irq_sense_tb.sv
module ext_irq_sense_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] pin_in = 2'b11;
   logic       gie = 1'b0;
   logic [1:0] ack = 2'b00;
   logic [1:0] reg_addr = 2'd0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic [1:0] irq_req, irq_sel;
   logic       irq_any;

   int vecs = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [7:0] m_ctl;
   logic [1:0] m_ena, m_flag, m_pin;
   logic       m_gie;

   always #(CLK_PERIOD/2) clk = ~clk;

   ext_irq_sense u_dut (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .gie(gie), .ack(ack),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_sel(irq_sel), .irq_any(irq_any));

   function automatic logic trig(input logic [1:0] mode, input logic o, input logic n);
      case (mode)
         2'b01:   return o != n;
         2'b10:   return o & !n;
         2'b11:   return !o & n;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [1:0] exp_req();
      logic [1:0] r;
      for (int c = 0; c < 2; c++) begin
         logic lvl;
         lvl  = (m_ctl[2*c +: 2] == 2'b00) && !m_pin[c];
         r[c] = (m_flag[c] | lvl) & m_ena[c] & m_gie;
      end
      return r;
   endfunction

   function automatic logic [1:0] exp_sel(input logic [1:0] r);
      return r[0] ? 2'b01 : (r[1] ? 2'b10 : 2'b00);
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      vecs++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      case (a)
         2'd0: m_ctl = d;
         2'd1: m_ena = {d[7], d[6]};
         2'd2: m_flag = m_flag & ~{d[7], d[6]};
         default: ;
      endcase
   endtask

   task automatic set_pin(input int c, input logic v);
      @(negedge clk);
      if (trig(m_ctl[2*c +: 2], m_pin[c], v)) m_flag[c] = 1'b1;
      pin_in[c] = v; m_pin[c] = v;
      repeat (4) @(negedge clk);
   endtask

   task automatic pulse_ack(input logic [1:0] v);
      @(negedge clk); ack = v;
      @(negedge clk); ack = 2'b00;
      m_flag = m_flag & ~v;
   endtask

   task automatic check_all(input string req);
      logic [7:0] d;
      logic [1:0] r;
      r = exp_req();
      rd(2'd2, d);
      check(req, d, {m_flag[1], m_flag[0], 6'b0});
      check(req, {6'b0, irq_req}, {6'b0, r});
      check(req, {6'b0, irq_sel}, {6'b0, exp_sel(r)});
      check(req, {7'b0, irq_any}, {7'b0, |r});
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      void'($urandom(32'd1234));
      m_ctl = 0; m_ena = 0; m_flag = 0; m_pin = 2'b11; m_gie = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd0, d); check("R1 ctl", d, 8'h00);
      rd(2'd1, d); check("R1 ena", d, 8'h00);
      check_all("R1");

      // R2 readback
      wr(2'd0, 8'hA5); rd(2'd0, d); check("R2 readback", d, 8'hA5);
      // R3 enable map
      wr(2'd1, 8'hFF); rd(2'd1, d); check("R3 ena map", d, 8'hC0);
      wr(2'd1, 8'h00); rd(2'd1, d); check("R3 ena clear", d, 8'h00);

      // R5 falling with upper ctl bits set (R2 no effect), latency
      wr(2'd0, 8'hF2);
      @(negedge clk); pin_in[0] = 1'b0; m_pin[0] = 1'b0;
      @(negedge clk);
      @(negedge clk); rd(2'd2, d); check("R5 not yet", d, 8'h00);
      @(negedge clk); rd(2'd2, d); check("R5 latency", d, 8'h40);
      m_flag[0] = 1'b1;
      wr(2'd2, 8'h40); check_all("R9 w1c");
      set_pin(0, 1'b1); check_all("R5 rise ignored");

      // R6 rising on channel 1
      wr(2'd0, 8'h0C);
      set_pin(1, 1'b0); check_all("R6 fall ignored");
      set_pin(1, 1'b1); check_all("R6 rise sets");
      check("R6 flag1", {6'b0, m_flag}, 8'h02);

      // R7 any change on both
      wr(2'd0, 8'h05); wr(2'd2, 8'hC0);
      set_pin(0, 1'b0); check_all("R7 fall");
      wr(2'd2, 8'h40);
      set_pin(0, 1'b1); check_all("R7 rise");
      check("R7 flag0", {6'b0, m_flag}, 8'h01);

      // R9 writing zero keeps flag; R10 ack clears only its channel
      set_pin(1, 1'b0);
      wr(2'd2, 8'h00); check_all("R9 zero write");
      pulse_ack(2'b01); check_all("R10 ack0");
      check("R10 ch1 kept", {6'b0, m_flag}, 8'h02);

      // R11 set wins over a simultaneous ack, flag already set
      @(negedge clk); pin_in[1] = 1'b1; m_pin[1] = 1'b1;
      @(negedge clk);
      @(negedge clk); ack = 2'b10;
      @(negedge clk); ack = 2'b00;
      rd(2'd2, d); check("R11 set wins", d, 8'h80);
      repeat (2) @(negedge clk);
      check_all("R11");

      // R8 level mode on channel 0
      wr(2'd2, 8'hC0);
      wr(2'd0, 8'h00); wr(2'd1, 8'hC0);
      @(negedge clk); gie = 1'b1; m_gie = 1'b1;
      @(negedge clk); pin_in[0] = 1'b0; m_pin[0] = 1'b0;
      @(negedge clk); check("R8 not yet", {6'b0, irq_req}, 8'h00);
      @(negedge clk); check("R8 level req", {6'b0, irq_req}, 8'h01);
      repeat (2) @(negedge clk);
      check_all("R8 low");
      set_pin(0, 1'b1); check_all("R8 no latch");

      // R12 gating
      wr(2'd0, 8'h05);
      set_pin(0, 1'b0);
      wr(2'd1, 8'h80); check_all("R12 ena off");
      wr(2'd1, 8'hC0);
      @(negedge clk); gie = 1'b0; m_gie = 1'b0;
      @(negedge clk); check_all("R12 gie off");
      @(negedge clk); gie = 1'b1; m_gie = 1'b1;
      @(negedge clk);

      // R13 priority
      set_pin(1, 1'b0); check_all("R13 both");
      check("R13 sel", {6'b0, irq_sel}, 8'h01);
      pulse_ack(2'b01); check_all("R13 ch1 only");

      // random phase
      for (int i = 0; i < 400; i++) begin
         int op;
         op = $urandom_range(0, 5);
         case (op)
            0, 1: set_pin($urandom_range(0, 1), 1'($urandom_range(0, 1)));
            2: wr(2'd0, 8'($urandom()));
            3: wr(2'd1, 8'($urandom()));
            4: if ($urandom_range(0, 1) == 0) wr(2'd2, 8'($urandom()));
               else pulse_ack(2'($urandom()));
            default: begin
               @(negedge clk); gie = 1'($urandom()); m_gie = gie;
               @(negedge clk);
            end
         endcase
         check_all("R2-mix R5 R6 R7 R8 R9 R10 R12 R13 random");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
   end
endmodule